// File: doc/BRIEF.md
# Programmable Serial Synthesizer Loader

This block programs up to three external frequency synthesizers over one shared serial bus. A host writes a 32-bit control word as four bytes, plus one control byte, through a small register bus. It then writes a start command. The block sends all 32 bits on a common data line, timed by a divided serial clock. It also drives one latch-enable strobe per synthesizer, and only the addressed synthesizer's strobe is asserted.

Software picks, for each transfer:
- which serial clock edge samples the data;
- the shift direction;
- the strobe's active level;
- whether the strobe pulses after the word or frames the whole word.

A readable status register reports busy and a sticky done flag. The register bus has no back-pressure: every write or read completes in the cycle it is presented. Read data appears on the following cycle. The serial outputs are plain output pins and have no handshake.

Top module: `synth_loader`

## Requirements
- R1: Reset, and the idle state after reset, give these levels: serial clock low, data low, all three strobes high (control byte resets to 0), busy 0 and done 0. Asserting reset during a transfer aborts it and returns the outputs to these levels.
- R2: During the word, each bit lasts DIV (default 128) system clocks. The serial clock spends the first DIV/2 of those clocks at its idle level and the second DIV/2 at the opposite level.
- R3: Control bit 0 selects the sampling edge: 0 means rising, 1 means falling. The serial clock idles at the value of bit 0. The data line changes only at the start of a bit period, so it is stable around the mid-bit active edge, and it is low whenever no bit is being sent.
- R4: Control bit 1 selects the direction. When it is 0, word bit 31 is sent first and bit 0 last. When it is 1, word bit 0 is sent first and bit 31 last.
- R5: Every transfer sends all 32 bits. Control bits 5:4 select the target strobe: 0, 1 or 2 selects that strobe, and 3 asserts no strobe. At most one strobe is ever active.
- R6: Control bit 2 sets the strobe active level: 1 means high, 0 means low. Inactive strobes sit at the inverse level.
- R7: Control bit 3 selects strobe timing. When it is 0, the target strobe is active for one DIV period after the last bit, with the serial clock idle and the data low. When it is 1, the target strobe is active from the first clock of bit 0 until the last bit period ends.
- R8: Writing 1 to bit 0 at address 5 while idle sets busy on the next cycle. Busy lasts 33·DIV cycles in mode 0 and 32·DIV cycles in mode 1. Busy then clears, and done sets, on the same edge.
- R9: A read of address 6 returns busy in bit 0 and done in bit 1 on the next cycle, with the other bits 0. The read clears done, unless done is being set on that same edge.
- R10: While busy, writes to the data, control or start addresses are ignored.
- R11: Addresses 0 to 3 hold word bytes 0 (bits 7:0) to 3 (bits 31:24), and address 4 holds the control byte. These values read back unchanged, including after a transfer. A cycle without a read returns 0 on the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| syn_clk | output | 1 | Shared serial clock |
| syn_data | output | 1 | Shared serial data |
| syn_le | output | 3 | Per-synthesizer latch-enable strobes |

## Verification
The assertions check several properties on every cycle:
- at most one strobe is active;
- the data line never changes inside a bit period;
- done always follows the end of a sequence;
- busy falls only on a finishing edge;
- locked registers stay stable across writes made while busy.

The exact bit order, clock phase, strobe window length for each timing mode, status read-clear ordering and the abort on reset are shown only by the bench scenarios. The bench compares every cycle against a time-since-start reference model under several mixes of edge, direction, polarity, mode and target.

// File: rtl/synth_loader_pkg.sv
package synth_loader_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LATCH = 2'd2
  } seq_state_t;

  // control byte layout, LSB first: edge, direction, polarity, timing, target
  typedef struct packed {
    logic [1:0] target;
    logic       hold;
    logic       act_high;
    logic       lsb_first;
    logic       fall_edge;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int SEL_W  = 2;

endpackage

// File: rtl/synth_loader_regs.sv
module synth_loader_regs
  import synth_loader_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              busy,
  input  logic              finish,
  output logic [WORD_W-1:0] word,
  output ctrl_t             ctrl,
  output logic              start_go
);
  localparam int NBYTES  = WORD_W / 8;
  localparam int A_CTRL  = NBYTES;
  localparam int A_START = NBYTES + 1;
  localparam int A_STAT  = NBYTES + 2;

  logic [WORD_W-1:0] data_q;
  ctrl_t             ctrl_q;
  logic              done_q;
  logic              wr_ok;
  logic              stat_rd;
  logic [7:0]        rd_val;

  assign wr_ok    = wr_en && !busy;
  assign stat_rd  = rd_en && (addr == ADDR_W'(A_STAT));
  assign start_go = wr_ok && (addr == ADDR_W'(A_START)) && wdata[0];
  assign word     = data_q;
  assign ctrl     = ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (wr_ok) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (addr == ADDR_W'(b)) data_q[b*8 +: 8] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_ok && addr == ADDR_W'(A_CTRL)) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done_q <= 1'b0;
    else if (finish)  done_q <= 1'b1;
    else if (stat_rd) done_q <= 1'b0;
  end

  always_comb begin
    rd_val = 8'h00;
    for (int b = 0; b < NBYTES; b++) begin
      if (addr == ADDR_W'(b)) rd_val = data_q[b*8 +: 8];
    end
    if (addr == ADDR_W'(A_CTRL)) rd_val = 8'(ctrl_q);
    if (addr == ADDR_W'(A_STAT)) rd_val = {6'b0, done_q, busy};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= 8'h00;
    else        rdata <= rd_en ? rd_val : 8'h00;
  end

  // R8
  finish_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> done_q);

  // R10
  locked_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> ($stable(data_q) && $stable(ctrl_q)));

endmodule

// File: rtl/synth_loader_clkdiv.sv
module synth_loader_clkdiv #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic second_half,
  output logic wrap
);
  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (!run)                   cnt_q <= '0;
    else if (cnt_q == CW'(DIV - 1))  cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  assign second_half = (cnt_q >= CW'(HALF));
  assign wrap        = run && (cnt_q == CW'(DIV - 1));

  // R2
  period_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && run) |=> (cnt_q == '0));

endmodule

// File: rtl/synth_loader_shifter.sv
module synth_loader_shifter #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              step,
  input  logic              lsb_first,
  output logic              serial_bit,
  output logic              last_bit
);
  localparam int BW = $clog2(WORD_W);

  logic [WORD_W-1:0] sh_q;
  logic [BW-1:0]     idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sh_q  <= load_word;
      idx_q <= '0;
    end else if (step) begin
      sh_q  <= lsb_first ? (sh_q >> 1) : (sh_q << 1);
      idx_q <= idx_q + 1'b1;
    end
  end

  assign serial_bit = lsb_first ? sh_q[0] : sh_q[WORD_W-1];
  assign last_bit   = (idx_q == BW'(WORD_W - 1));

endmodule

// File: rtl/synth_loader_seq.sv
module synth_loader_seq
  import synth_loader_pkg::*;
#(
  parameter int N_SYNTH = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_go,
  input  logic               wrap,
  input  logic               second_half,
  input  logic               last_bit,
  input  logic               serial_bit,
  input  ctrl_t              ctrl,
  output logic               busy,
  output logic               finish,
  output logic               load,
  output logic               step,
  output logic               sclk,
  output logic               sdata,
  output logic [N_SYNTH-1:0] strobe
);
  seq_state_t state_q, state_d;
  logic       strobe_on;
  logic       word_end;

  assign word_end = (state_q == ST_SHIFT) && wrap && last_bit;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_go) state_d = ST_SHIFT;
      ST_SHIFT: if (word_end) state_d = ctrl.hold ? ST_IDLE : ST_LATCH;
      ST_LATCH: if (wrap)     state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy      = (state_q != ST_IDLE);
  assign finish    = (word_end && ctrl.hold) || ((state_q == ST_LATCH) && wrap);
  assign load      = start_go;
  assign step      = (state_q == ST_SHIFT) && wrap;
  assign sclk      = (state_q == ST_SHIFT) ? (ctrl.fall_edge ^ second_half) : ctrl.fall_edge;
  assign sdata     = (state_q == ST_SHIFT) && serial_bit;
  assign strobe_on = (state_q == ST_LATCH) || ((state_q == ST_SHIFT) && ctrl.hold);

  for (genvar i = 0; i < N_SYNTH; i++) begin : g_strobe
    assign strobe[i] = (strobe_on && ctrl.target == SEL_W'(i)) ? ctrl.act_high : !ctrl.act_high;
  end

  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(strobe ^ {N_SYNTH{!ctrl.act_high}}) <= 1);

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(step)) |-> $stable(sdata));

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(finish));

endmodule

// File: rtl/synth_loader.sv
module synth_loader
  import synth_loader_pkg::*;
#(
  parameter int  DIV     = 128,
  parameter int  WORD_W  = 32,
  parameter int  N_SYNTH = 3,
  localparam int ADDR_W  = $clog2(WORD_W / 8 + 3)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               syn_clk,
  output logic               syn_data,
  output logic [N_SYNTH-1:0] syn_le
);
  logic              busy, finish, load, step, start_go;
  logic              second_half, wrap, serial_bit, last_bit;
  logic [WORD_W-1:0] word;
  ctrl_t             ctrl;

  synth_loader_regs #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .finish(finish),
    .word(word), .ctrl(ctrl), .start_go(start_go)
  );

  synth_loader_clkdiv #(.DIV(DIV)) div_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .second_half(second_half), .wrap(wrap)
  );

  synth_loader_shifter #(.WORD_W(WORD_W)) shf_i (
    .clk(clk), .rst_n(rst_n), .load(load), .load_word(word), .step(step),
    .lsb_first(ctrl.lsb_first), .serial_bit(serial_bit), .last_bit(last_bit)
  );

  synth_loader_seq #(.N_SYNTH(N_SYNTH)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_go(start_go), .wrap(wrap),
    .second_half(second_half), .last_bit(last_bit), .serial_bit(serial_bit),
    .ctrl(ctrl), .busy(busy), .finish(finish), .load(load), .step(step),
    .sclk(syn_clk), .sdata(syn_data), .strobe(syn_le)
  );

  // R3
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (!syn_data && syn_clk == ctrl.fall_edge));

endmodule

// File: tb/synth_loader_tb_top.sv
module synth_loader_tb_top;
  localparam int DIV  = 128;
  localparam int HALF = DIV / 2;
  localparam int WB   = 32 * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       syn_clk, syn_data;
  logic [2:0] syn_le;

  int errors = 0, checks = 0, cyc = 0;

  synth_loader dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .syn_clk(syn_clk), .syn_data(syn_data), .syn_le(syn_le)
  );

  always #4 clk = ~clk;

  // reference model: time since start
  logic [31:0] m_data, m_word;
  logic [5:0]  m_ctrl;
  logic        m_busy, m_done, m_fin, m_ob;
  logic [7:0]  m_rdata, m_rv;
  int          m_t, m_len;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = 0; m_word = 0; m_ctrl = 0; m_busy = 0; m_done = 0; m_t = 0; m_rdata = 0;
    end else begin
      m_rv = 8'h00;
      if (reg_addr < 4)       m_rv = m_data[reg_addr*8 +: 8];
      else if (reg_addr == 4) m_rv = {2'b00, m_ctrl};
      else if (reg_addr == 6) m_rv = {6'b0, m_done, m_busy};
      m_rdata = reg_rd ? m_rv : 8'h00;
      m_ob = m_busy; m_fin = 0;
      m_len = m_ctrl[3] ? WB : WB + DIV;
      if (m_busy) begin
        m_t++;
        if (m_t == m_len) begin m_busy = 0; m_fin = 1; end
      end
      if (reg_wr && !m_ob) begin
        if (reg_addr < 4)       m_data[reg_addr*8 +: 8] = reg_wdata;
        else if (reg_addr == 4) m_ctrl = reg_wdata[5:0];
        else if (reg_addr == 5 && reg_wdata[0]) begin m_busy = 1; m_t = 0; m_word = m_data; end
      end
      if (m_fin) m_done = 1;
      else if (reg_rd && reg_addr == 6) m_done = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0d", tag, act, exp, m_t);
    end
  endtask

  // compare all outputs against the model every cycle
  always @(negedge clk) begin
    logic ex_clk, ex_dat, on;
    logic [2:0] ex_le;
    int bn;
    cyc++;
    if (rst_n) begin
      ex_clk = m_ctrl[0]; ex_dat = 0; on = 0;
      if (m_busy && m_t < WB) begin
        bn = m_t / DIV;
        ex_clk = m_ctrl[0] ^ ((m_t % DIV) >= HALF);
        ex_dat = m_word[m_ctrl[1] ? bn : 31 - bn];
        on = m_ctrl[3];
      end else if (m_busy) on = !m_ctrl[3];
      for (int i = 0; i < 3; i++)
        ex_le[i] = (on && m_ctrl[5:4] == i) ? m_ctrl[2] : !m_ctrl[2];
      chk(syn_clk == ex_clk, "R2/R3 serial clock", 32'(syn_clk), 32'(ex_clk));
      chk(syn_data == ex_dat, "R4 serial data order", 32'(syn_data), 32'(ex_dat));
      chk(syn_le == ex_le, "R5/R6/R7 strobes", 32'(syn_le), 32'(ex_le));
      chk(reg_rdata == m_rdata, "R9/R11 read data", 32'(reg_rdata), 32'(m_rdata));
    end
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic load_word(input logic [31:0] w, input logic [5:0] c);
    for (int b = 0; b < 4; b++) wr(3'(b), w[b*8 +: 8]);
    wr(3'd4, {2'b00, c});
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
  endtask

  logic [7:0] v;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset levels
    chk(syn_clk == 0 && syn_data == 0, "R1 reset clk/data", {syn_clk, syn_data}, 0);
    chk(syn_le == 3'b111, "R1 reset strobes", 32'(syn_le), 32'h7);
    rst_n = 1;
    rd(3'd6, v); chk(v == 8'h00, "R1 reset status", v, 0);

    // rising edge, MSB first, active low, pulse after word, target 0
    load_word(32'hA5C3_0F81, 6'b00_0_0_0_0);
    wr(3'd5, 8'h01);
    rd(3'd6, v); chk(v == 8'h01, "R8 busy while sending", v, 8'h01);
    wait_idle();
    rd(3'd6, v); chk(v == 8'h02, "R9 done after sequence", v, 8'h02);
    rd(3'd6, v); chk(v == 8'h00, "R9 done cleared by read", v, 8'h00);
    rd(3'd3, v); chk(v == 8'hA5, "R11 byte 3 kept", v, 8'hA5);
    rd(3'd0, v); chk(v == 8'h81, "R11 byte 0 kept", v, 8'h81);

    // falling edge, LSB first, active high, hold mode, target 2; writes while busy
    load_word(32'h1234_8001, 6'b10_1_1_1_1);
    wr(3'd5, 8'h01);
    wr(3'd0, 8'hEE); wr(3'd4, 8'h00); wr(3'd5, 8'h01);
    wait_idle();
    rd(3'd0, v); chk(v == 8'h01, "R10 data write ignored while busy", v, 8'h01);
    rd(3'd4, v); chk(v == 8'h2F, "R10 control write ignored while busy", v, 8'h2F);

    // rising edge, MSB first, active high, pulse mode, target 1
    load_word(32'hFFFF_0000, 6'b01_0_1_0_0);
    wr(3'd5, 8'h01);
    wait_idle();
    rd(3'd6, v); chk(v == 8'h02, "R8 done after pulse mode", v, 8'h02);

    // target 3 selects no strobe, falling edge, MSB first, active low
    load_word(32'h5555_AAAA, 6'b11_0_0_0_1);
    wr(3'd5, 8'h01);
    wait_idle();
    chk(syn_le == 3'b111, "R5 no strobe for target 3", 32'(syn_le), 32'h7);

    // abort by reset mid-transfer
    load_word(32'h0F0F_F0F0, 6'b00_1_1_0_0);
    wr(3'd5, 8'h01);
    repeat (700) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(syn_clk == 0 && syn_data == 0, "R1 abort clk/data", {syn_clk, syn_data}, 0);
    chk(syn_le == 3'b111, "R1 abort strobes", 32'(syn_le), 32'h7);
    rst_n = 1;
    rd(3'd6, v); chk(v == 8'h00, "R1 abort status", v, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule